// File: doc/BRIEF.md
# Early-Terminating Iterative Multiplier

This block multiplies two 32-bit integers over several clock cycles. The number of cycles depends on how large the multiplier operand is. Each pass consumes one slice of the multiplier and adds a partial product into a running 64-bit sum. The unit inspects the multiplier at start. It skips the upper slices when they hold only sign extension, or only zeros when the operand is unsigned. A short form returns the low 32 bits of the product. A long form returns all 64 bits, with the operands treated as signed or unsigned. Either form can add an accumulator value, and either form can update negative and zero flags.

A caller pulses `start` with the operands and mode bits while `busy` is low. The unit counts its own cycles. It raises `lo_valid` and `hi_valid` in the exact cycle each half of the result becomes usable. The count is taken from the start cycle, where the start cycle is cycle 0. `busy` tells the caller when the next operation may be issued. An operation may be issued while the previous result is still draining, except when flags are being set.

Top module: `itermul`

## Requirements
- R1: The multiplier's class is chosen at start. Class 1: bits [31:15] are all equal. Class 2: bits [31:27] are all equal, but class 1 does not apply. Class 3: any other operand. A short operation without flags raises `lo_valid` 2, 3 or 4 cycles after start for classes 1, 2 and 3.
- R2: A short operation without flags keeps `busy` high from cycle 1 until just before its issue cycle. A new start is accepted 1, 2 or 3 cycles after the previous start, by class.
- R3: With `set_flags`=1, a short operation holds `busy` until its result cycle. The next start is accepted 2, 3 or 4 cycles after the current start.
- R4: A long operation without flags raises `lo_valid` 2, 3 or 4 cycles after start, by class. It raises `hi_valid` exactly one cycle after `lo_valid`.
- R5: For a long operation with `is_signed`=0, the class tests require the tested bits to be all zeros. An all-ones pattern in those bits gives class 3.
- R6: A long accumulating operation without flags accepts the next start 2, 3 or 4 cycles after its own start. A long operation with flags raises `lo_valid` and `hi_valid` together 3, 4 or 5 cycles after start, and accepts the next start in that same cycle.
- R7: The short form produces the low 32 bits of `mcand*mplier`, plus `acc_lo` when `do_acc`=1. The long form produces the 64-bit product of the operands, signed or unsigned per `is_signed`, plus {`acc_hi`,`acc_lo`} when `do_acc`=1.
- R8: With `set_flags`=1, the flags update in the cycle the final valid strobe is raised. `flag_n` takes bit 31 of the result, or bit 63 for the long form. `flag_z` is 1 when the whole result is zero. Operations with `set_flags`=0 leave the flags unchanged.
- R9: A start asserted while `busy` is high is ignored. The running operation completes with its own result and its own strobe timing.
- R10: `res_lo` and `res_hi` change only in a cycle in which their own valid strobe is high. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new operation |
| is_long | input | 1 | 1: 64-bit result form; 0: 32-bit result form |
| is_signed | input | 1 | Long form operand signedness |
| do_acc | input | 1 | Add the accumulator input |
| set_flags | input | 1 | Update N/Z flags |
| mcand | input | 32 | Multiplicand |
| mplier | input | 32 | Multiplier; its magnitude sets the latency |
| acc_lo | input | 32 | Accumulator low word |
| acc_hi | input | 32 | Accumulator high word (long form) |
| busy | output | 1 | High while a start would be ignored |
| lo_valid | output | 1 | Low result word valid this cycle |
| hi_valid | output | 1 | High result word valid this cycle |
| res_lo | output | 32 | Low result word |
| res_hi | output | 32 | High result word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bench targets operands on the class boundaries, such as 0xFFFF8000 and 0xF8000001. A wrong slice-skip test would give the wrong strobe cycle on these operands, or a product built without the top slice. Unsigned long operands with all-ones upper bits are included. A unit that wrongly terminated early on them would return a value off by 2^32 times the multiplicand. Two directed cases are also covered. In the first, a new start lands in the same cycle as the final pass of the previous operation. A design that confused the two would drop or corrupt one result. In the second, a start arrives while `busy` is high. A design that accepted it would restart the sequence and deliver a foreign product.

// File: rtl/itermul.sv
module itermul (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_long,
  input  logic        is_signed,
  input  logic        do_acc,
  input  logic        set_flags,
  input  logic [31:0] mcand,
  input  logic [31:0] mplier,
  input  logic [31:0] acc_lo,
  input  logic [31:0] acc_hi,
  output logic        busy,
  output logic        lo_valid,
  output logic        hi_valid,
  output logic [31:0] res_lo,
  output logic [31:0] res_hi,
  output logic        flag_n,
  output logic        flag_z
);
  localparam int SLICE1 = 15;
  localparam int SLICE2 = 27;

  logic        eng, long_r, flg_r, pend_v, pend_flg;
  logic [2:0]  cnt;
  logic [1:0]  np, xtra;
  logic [32:0] a_r, r_r;
  logic [63:0] acc_r, pend;

  // operand extension: short form always tested as signed
  wire         sx      = is_long ? is_signed : 1'b1;
  wire  [32:0] a_in    = {sx & mcand[31], mcand};
  wire  [32:0] r_in    = {sx & mplier[31], mplier};
  wire         fits17  = (&r_in[32:SLICE1]) | ~(|r_in[32:SLICE1]);
  wire         fits28  = (&r_in[32:SLICE2]) | ~(|r_in[32:SLICE2]);
  wire  [1:0]  np_in   = fits17 ? 2'd1 : (fits28 ? 2'd2 : 2'd3);
  wire  [1:0]  xtra_in = set_flags ? (is_long ? 2'd2 : 2'd1) : {1'b0, is_long & do_acc};
  wire  [63:0] acc_in  = do_acc ? (is_long ? {acc_hi, acc_lo} : {32'b0, acc_lo}) : 64'b0;

  wire  [2:0]  issue_c = {1'b0, np} + {1'b0, xtra};
  wire  [2:0]  end_c   = {1'b0, np} + {2'b0, xtra == 2'd2};
  assign busy = eng && (cnt < issue_c);
  wire         start_ok = start && !busy;
  wire         last     = cnt == {1'b0, np};
  wire         fin      = eng && last;

  logic [4:0]  sh;
  always_comb begin
    case (cnt)
      3'd1:    sh = 5'd0;
      3'd2:    sh = 5'(SLICE1);
      default: sh = 5'(SLICE2);
    endcase
  end

  // last pass takes the remaining bits as a signed value
  wire  [32:0] rsh   = 33'($signed(r_r) >>> sh);
  wire  [15:0] chunk = last ? rsh[15:0] :
                       (cnt == 3'd1 ? {1'b0, r_r[SLICE1-1:0]} : {4'b0, r_r[SLICE2-1:SLICE1]});
  wire  [48:0] pp    = 49'($signed({{16{a_r[32]}}, a_r}) * $signed({{33{chunk[15]}}, chunk}));
  wire  [63:0] ppx   = {{15{pp[48]}}, pp} << sh;
  wire  [63:0] sum   = acc_r + ppx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng <= 1'b0; cnt <= 3'd0; np <= 2'd0; xtra <= 2'd0;
      long_r <= 1'b0; flg_r <= 1'b0; a_r <= '0; r_r <= '0; acc_r <= '0;
      pend_v <= 1'b0; pend_flg <= 1'b0; pend <= '0;
      lo_valid <= 1'b0; hi_valid <= 1'b0; res_lo <= '0; res_hi <= '0;
      flag_n <= 1'b0; flag_z <= 1'b0;
    end else begin
      lo_valid <= 1'b0;
      hi_valid <= 1'b0;
      pend_v   <= 1'b0;
      if (start_ok) begin
        eng <= 1'b1; cnt <= 3'd1; np <= np_in; xtra <= xtra_in;
        long_r <= is_long; flg_r <= set_flags;
        a_r <= a_in; r_r <= r_in; acc_r <= acc_in;
      end else if (eng) begin
        cnt <= cnt + 3'd1;
        if (cnt == end_c) eng <= 1'b0;
        if (cnt <= {1'b0, np}) acc_r <= sum;
      end
      if (fin) begin
        if (!(long_r && flg_r)) begin
          res_lo   <= sum[31:0];
          lo_valid <= 1'b1;
        end
        if (flg_r && !long_r) begin
          flag_n <= sum[31];
          flag_z <= sum[31:0] == 32'b0;
        end
        pend     <= sum;
        pend_v   <= long_r;
        pend_flg <= flg_r;
      end
      if (pend_v) begin
        res_hi   <= pend[63:32];
        hi_valid <= 1'b1;
        if (pend_flg) begin
          res_lo   <= pend[31:0];
          lo_valid <= 1'b1;
          flag_n   <= pend[63];
          flag_z   <= pend == 64'b0;
        end
      end
    end
  end
endmodule

// File: rtl/itermul_chk.sv
module itermul_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lo_valid,
  input logic        hi_valid,
  input logic [31:0] res_lo,
  input logic [31:0] res_hi,
  input logic        flag_n,
  input logic        flag_z
);
  assert_lo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_lo) |-> lo_valid);
  assert_hi_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_hi) |-> hi_valid);
  assert_flag_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({flag_n, flag_z}) |-> lo_valid);
  assert_zero_not_neg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z |-> !flag_n);
  assert_hi_after_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hi_valid |-> (lo_valid || $past(lo_valid)));
endmodule

bind itermul itermul_chk u_chk (.*);

// File: tb/itermul_tb.sv
module itermul_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, is_long = 1'b0, is_signed = 1'b0, do_acc = 1'b0, set_flags = 1'b0;
  logic [31:0] mcand = '0, mplier = '0, acc_lo = '0, acc_hi = '0;
  logic busy, lo_valid, hi_valid, flag_n, flag_z;
  logic [31:0] res_lo, res_hi;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  itermul u_dut (.*);

  // {is_long,is_signed,do_acc,set_flags}, mcand, mplier, acc_lo, acc_hi
  localparam int NV = 13;
  localparam logic [131:0] VEC [NV] = '{
    {4'b0000, 32'd7,         32'd5,         32'd0,   32'd0},
    {4'b0010, 32'd3,         32'hFFFF8000,  32'd100, 32'd0},
    {4'b0000, 32'h00000011,  32'h00123456,  32'd0,   32'd0},
    {4'b0010, 32'h9ABCDEF0,  32'h12345678,  32'h55,  32'd0},
    {4'b0001, 32'd1,         32'hFFFFFFFF,  32'd0,   32'd0},
    {4'b0001, 32'd0,         32'h40000000,  32'd0,   32'd0},
    {4'b1000, 32'hDEADBEEF,  32'h0000ABCD,  32'd0,   32'd0},
    {4'b1000, 32'hFFFFFFFF,  32'hFFFFFFFF,  32'd0,   32'd0},
    {4'b1100, 32'h80000000,  32'hFFFFFFFF,  32'd0,   32'd0},
    {4'b1110, 32'h12345678,  32'hF8000001,  32'd9,   32'hFFFFFFFF},
    {4'b1000, 32'h12345678,  32'hF8000001,  32'd0,   32'd0},
    {4'b1111, 32'hC0000001,  32'h7FFFFFFF,  32'd1,   32'd2},
    {4'b1001, 32'd0,         32'd2,         32'd0,   32'd0}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int cls(input logic [31:0] r, input bit uns);
    if (uns) return (r[31:15] == 0) ? 1 : (r[31:27] == 0) ? 2 : 3;
    return (&r[31:15] || r[31:15] == 0) ? 1 : (&r[31:27] || r[31:27] == 0) ? 2 : 3;
  endfunction

  function automatic logic [63:0] model(input logic [3:0] m, input logic [31:0] a, b, al, ah);
    logic [63:0] p;
    if (m[3] && m[2]) p = 64'($signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b}));
    else              p = {32'b0, a} * {32'b0, b};
    if (!m[3]) return {32'b0, p[31:0] + (m[1] ? al : 32'b0)};
    return p + (m[1] ? {ah, al} : 64'b0);
  endfunction

  task automatic run_vec(input logic [131:0] v);
    logic [3:0] m;
    int p, exp_lo, exp_hi, exp_iss, lo_c, hi_c, iss_c;
    logic [63:0] e;
    logic [31:0] got_lo, got_hi;
    logic fn0, fz0;
    m = v[131:128];
    e = model(m, v[127:96], v[95:64], v[63:32], v[31:0]);
    p = cls(v[95:64], m[3] && !m[2]);
    if (m[0]) begin
      exp_lo  = m[3] ? p + 2 : p + 1;
      exp_iss = exp_lo;
    end else begin
      exp_lo  = p + 1;
      exp_iss = (m[3] && m[1]) ? p + 1 : p;
    end
    exp_hi = m[3] ? (m[0] ? exp_lo : exp_lo + 1) : -1;
    fn0 = flag_n; fz0 = flag_z;
    {is_long, is_signed, do_acc, set_flags} = m;
    mcand = v[127:96]; mplier = v[95:64]; acc_lo = v[63:32]; acc_hi = v[31:0];
    start = 1'b1;
    lo_c = -1; hi_c = -1; iss_c = -1; got_lo = '0; got_hi = '0;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (lo_valid && lo_c < 0) begin lo_c = c; got_lo = res_lo; end
      if (hi_valid && hi_c < 0) begin hi_c = c; got_hi = res_hi; end
      if (!busy && iss_c < 0) iss_c = c;
    end
    check(lo_c == exp_lo, m[3] ? (m[0] ? "R6 lo cycle" : "R4 lo cycle") : "R1 lo cycle", 64'(lo_c), 64'(exp_lo));
    check(iss_c == exp_iss, m[0] ? (m[3] ? "R6 issue" : "R3 issue") : (m[3] ? "R6 issue" : "R2 issue"), 64'(iss_c), 64'(exp_iss));
    check(got_lo == e[31:0], "R7 low word", 64'(got_lo), 64'(e[31:0]));
    if (m[3]) begin
      check(hi_c == exp_hi, "R4 hi cycle (R5 class)", 64'(hi_c), 64'(exp_hi));
      check(got_hi == e[63:32], "R7 high word", 64'(got_hi), 64'(e[63:32]));
    end else
      check(hi_c == -1, "R4 no hi strobe on short form", 64'(hi_c), 64'hFFFFFFFFFFFFFFFF);
    if (m[0]) begin
      check(flag_n == (m[3] ? e[63] : e[31]), "R8 N flag", 64'(flag_n), 64'(m[3] ? e[63] : e[31]));
      check(flag_z == (m[3] ? e == 0 : e[31:0] == 0), "R8 Z flag", 64'(flag_z), 64'(m[3] ? e == 0 : e[31:0] == 0));
    end else
      check({flag_n, flag_z} == {fn0, fz0}, "R8 flags held", 64'({flag_n, flag_z}), 64'({fn0, fz0}));
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt_v;
    logic [31:0] seen;
    repeat (3) @(negedge clk);
    check({busy, lo_valid, hi_valid, flag_n, flag_z} == 0 && res_lo == 0 && res_hi == 0,
          "R10 reset state", {busy, lo_valid, hi_valid, res_lo[0], res_hi[0]}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // back-to-back class 1 short ops (R2): second start in cycle 1
    {is_long, is_signed, do_acc, set_flags} = 4'b0000;
    mcand = 32'd11; mplier = 32'd13; start = 1'b1;
    @(negedge clk);
    check(!busy, "R2 busy low in cycle 1", 64'(busy), 0);
    mcand = 32'd17; mplier = 32'd19;
    @(negedge clk);
    start = 1'b0;
    check(lo_valid && res_lo == 32'd143, "R2 first result cycle 2", {lo_valid, res_lo}, {1'b1, 32'd143});
    @(negedge clk);
    check(lo_valid && res_lo == 32'd323, "R2 second result cycle 3", {lo_valid, res_lo}, {1'b1, 32'd323});
    repeat (4) @(negedge clk);

    // start while busy is ignored (R9)
    mcand = 32'd3; mplier = 32'h12345678; start = 1'b1;
    @(negedge clk);
    check(busy, "R9 busy in cycle 1", 64'(busy), 1);
    mcand = 32'd5; mplier = 32'd2;
    @(negedge clk);
    start = 1'b0;
    cnt_v = 0; seen = '0;
    for (int c = 2; c <= 9; c++) begin
      if (lo_valid) begin cnt_v++; seen = res_lo; end
      @(negedge clk);
    end
    check(cnt_v == 1, "R9 single strobe", 64'(cnt_v), 1);
    check(seen == 32'h369D0368, "R9 original product kept", 64'(seen), 64'h369D0368);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule